// File: doc/BRIEF.md
# Grouped Interrupt Flag Collector With Read-Before-Clear

This block gathers single-cycle event pulses from a set of peripheral sources and holds each one as a sticky flag. Sources are gathered into groups of sixteen. Each group has three 16-bit registers on a simple synchronous register bus: a flag register, a mask register and a read-only request register. Each group drives one interrupt request line toward an interrupt controller. The number of groups is a parameter. A second parameter marks, for each bit, whether a source is actually wired to it.

Software can poll the flags or take interrupts. A flag can only be removed by a write of zero, and only after software has read that flag as one. This guards against losing an event that arrives between a read and the clear that follows it. The all-ones-except-one write convention clears one flag and leaves its neighbours alone.

Top module: `irq_flag_groups`

## Requirements
- R1: A pulse on `evt_i[n]` sets the flag of source n at the next clock edge, and the flag stays set until a valid clear.
- R2: Flags are set whether or not the matching mask bit is 1. With the mask bit at 0, the group's `irq_o` stays 0.
- R3: A write of 0 to a flag bit clears it only if that bit was returned as 1 by a flag register read since it was last set. A write of 0 to a flag that has not been read that way leaves it set.
- R4: Writing 1 to a flag bit never changes it. A write of all ones with a single 0 clears only that one armed flag.
- R5: Each request bit is the AND of the flag bit and the mask bit. Writes to the request register are ignored.
- R6: The mask register is fully read/write, with one bit per source.
- R7: Source n belongs to group n/16, at bit n mod 16. The register address is {group, sel}, where sel 0 is the flag register, 1 the mask register, 2 the request register and 3 reads as zero.
- R8: Bits marked unimplemented in `IMPL_MASK` always read 0 in the flag register and never set.
- R9: When an event and a valid clear hit the same bit in the same cycle, the event wins. The flag stays 1 and must be read again before a clear takes effect.
- R10: After reset, the flags, masks, read arming, `rdata` and `irq_o` are all zero.
- R11: `irq_o[g]` is a registered OR of group g's request bits. It changes one cycle after the flag or mask change.
- R12: Read data appears on `rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_GROUPS*16 | Event pulses, one per source |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | GSEL_W+2 | {group, register select} |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq_o | output | NUM_GROUPS | Interrupt request per group |

## Verification
The two functions that can land in the same cycle are a new event on a flag and a software clear of that same flag. The bench first arms a flag by reading it. It then raises that source's event pulse in the very cycle that carries the clearing write. A correct design must show the flag still set. A second zero-write must also leave it set, because the new occurrence has not been read. The bench then reads the flag and writes zero once more, and this time the flag must clear.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int GRP_W = 16;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_MASK = 2'd1,
    SEL_REQ  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // source index -> group (quotient) and bit (remainder)
  function automatic int src_group(input int n);
    return n / GRP_W;
  endfunction

  function automatic int src_bit(input int n);
    return n % GRP_W;
  endfunction
endpackage

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags,
  output logic [W-1:0] armed
);
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;
  logic [W-1:0] seen_v;

  always_comb begin
    set_v  = evt & IMPL;
    clr_v  = (wr_hit ? ~wdata : '0) & armed & flags;
    seen_v = rd_hit ? flags : '0;
  end

  // priority per bit: event > clear > read-arm
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= (set_v | (flags & ~clr_v)) & IMPL;
      armed <= ~set_v & ~clr_v & (armed | seen_v);
    end
  end
endmodule

// File: rtl/irqf_group.sv
module irqf_group
  import irqf_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags,
  output logic [W-1:0] armed,
  output logic [W-1:0] mask,
  output logic [W-1:0] rd_val,
  output logic         irq
);
  logic         flag_rd;
  logic         flag_wr;
  logic         mask_wr;
  logic [W-1:0] req;

  assign flag_rd = rd_hit && (sel == SEL_FLAG);
  assign flag_wr = wr_hit && (sel == SEL_FLAG);
  assign mask_wr = wr_hit && (sel == SEL_MASK);

  irqf_flag_bank #(.W(W), .IMPL(IMPL)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .rd_hit (flag_rd),
    .wr_hit (flag_wr),
    .wdata  (wdata),
    .flags  (flags),
    .armed  (armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else if (mask_wr) mask <= wdata;
  end

  assign req = flags & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |req;
  end

  always_comb begin
    unique case (sel)
      SEL_FLAG: rd_val = flags;
      SEL_MASK: rd_val = mask;
      SEL_REQ:  rd_val = req;
      default:  rd_val = '0;
    endcase
  end
endmodule

// File: rtl/irq_flag_groups.sv
module irq_flag_groups
  import irqf_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int GW = irqf_pkg::GRP_W,
  parameter logic [NUM_GROUPS*GW-1:0] IMPL_MASK =
    ~((NUM_GROUPS*GW)'(1) | ((NUM_GROUPS*GW)'(1) << (GW-1))),
  localparam int NSRC   = NUM_GROUPS * GW,
  localparam int GSEL_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ADDR_W = GSEL_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       evt_i,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [GW-1:0]         wdata,
  output logic [GW-1:0]         rdata,
  output logic [NUM_GROUPS-1:0] irq_o
);
  logic [GSEL_W-1:0] grp_idx;
  reg_sel_e          sel;
  logic [GW-1:0]     grp_evt [NUM_GROUPS];
  logic [GW-1:0]     grp_rd  [NUM_GROUPS];
  logic [GW-1:0]     rd_mux;
  // flattened state for the checker
  logic [NSRC-1:0]   st_all;
  logic [NSRC-1:0]   arm_all;
  logic [NSRC-1:0]   en_all;

  assign grp_idx = addr[ADDR_W-1:2];
  assign sel     = reg_sel_e'(addr[1:0]);

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) grp_evt[g] = '0;
    for (int n = 0; n < NSRC; n++) grp_evt[src_group(n)][src_bit(n)] = evt_i[n];
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = (grp_idx == GSEL_W'(g));

    irqf_group #(.W(GW), .IMPL(IMPL_MASK[g*GW +: GW])) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (grp_evt[g]),
      .rd_hit (rd_en && hit),
      .wr_hit (wr_en && hit),
      .sel    (sel),
      .wdata  (wdata),
      .flags  (st_all[g*GW +: GW]),
      .armed  (arm_all[g*GW +: GW]),
      .mask   (en_all[g*GW +: GW]),
      .rd_val (grp_rd[g]),
      .irq    (irq_o[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (grp_idx == GSEL_W'(g)) rd_mux = grp_rd[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
  parameter int NG = 2,
  parameter int GW = 16,
  parameter logic [NG*GW-1:0] IMPL = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NG*GW-1:0] evt_i,
  input logic [NG*GW-1:0] st_all,
  input logic [NG*GW-1:0] arm_all,
  input logic [NG*GW-1:0] en_all,
  input logic [NG-1:0]    irq_o
);
  logic [NG*GW-1:0] live_evt;
  logic [NG-1:0]    irq_want;

  assign live_evt = evt_i & IMPL;

  always_comb begin
    for (int g = 0; g < NG; g++)
      irq_want[g] = |(st_all[g*GW +: GW] & en_all[g*GW +: GW]);
  end

  // R1: an implemented event leaves its flag set on the next cycle
  a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|live_evt) |=> ((st_all & $past(live_evt)) == $past(live_evt)));

  // R3: a flag may only fall if it was armed the cycle before
  a_r3_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(st_all) & ~st_all) & ~$past(arm_all)) == '0));

  // R8: unimplemented positions never hold a flag
  a_r8_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_all & ~IMPL) == '0));

  // R9: a new event leaves its bit unarmed
  a_r9_event_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (|live_evt) |=> ((arm_all & $past(live_evt)) == '0));

  // R11: request line follows flags AND mask one cycle later
  a_r11_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o == $past(irq_want)));
endmodule

bind irq_flag_groups irqf_checker #(
  .NG(NUM_GROUPS), .GW(GW), .IMPL(IMPL_MASK)
) u_irqf_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt_i   (evt_i),
  .st_all  (st_all),
  .arm_all (arm_all),
  .en_all  (en_all),
  .irq_o   (irq_o)
);

// File: tb/tb_irq_flag_groups.sv
module tb_irq_flag_groups;
  localparam int NG = 2;
  localparam int NS = NG * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] evt_i = '0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [NG-1:0] irq_o;

  int checks = 0;
  int errors = 0;
  logic rd_seen = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #2 clk = ~clk;  // 250 MHz

  irq_flag_groups dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: R12, data is valid in the cycle after the strobe
  always @(posedge clk) rd_seen <= rd_en && rst_n;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sbq.size() == 0) check("R12 unexpected read", rdata, 16'h0);
      else begin
        sb_item_t it;
        it = sbq.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  // driver tasks, entered and left on a falling edge
  task automatic rd(input int g, input int s, input logic [15:0] exp, input string tag);
    sb_item_t it;
    addr = {g[0], s[1:0]};
    rd_en = 1'b1;
    it.exp = exp;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input int g, input int s, input logic [15:0] d);
    addr = {g[0], s[1:0]};
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [NS-1:0] v);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  function automatic logic [NS-1:0] src(input int n);
    return NS'(1) << n;
  endfunction

  initial begin
    repeat (4000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 rdata", rdata, 16'h0);
    check("R10 irq", {14'h0, irq_o}, 16'h0);
    rd(0, 0, 16'h0000, "R10 flags");
    rd(0, 1, 16'h0000, "R10 mask");
    rd(0, 2, 16'h0000, "R10 req");

    // events on src 0,15 (unimplemented), 3 and 17
    pulse(src(0) | src(3) | src(15) | src(17));
    wr(0, 0, 16'hFFF7);                        // not yet read: no clear
    rd(0, 0, 16'h0008, "R3 unarmed clear ignored / R1 / R8");
    rd(1, 0, 16'h0002, "R7 src17 -> group1 bit1");
    check("R2 irq with mask off", {14'h0, irq_o}, 16'h0);
    wr(0, 0, 16'hFFFF);
    rd(0, 0, 16'h0008, "R4 ones have no effect");
    pulse(src(5));
    rd(0, 0, 16'h0028, "R1 second flag");
    wr(0, 0, 16'hFFF7);
    rd(0, 0, 16'h0020, "R4 single clear");

    // masks and request
    wr(0, 1, 16'h0020);
    check("R11 irq not yet", {15'h0, irq_o[0]}, 16'h0);
    @(negedge clk);
    check("R11 irq raised", {15'h0, irq_o[0]}, 16'h1);
    rd(0, 1, 16'h0020, "R6 mask readback");
    rd(0, 2, 16'h0020, "R5 request");
    wr(0, 2, 16'hFFFF);
    rd(0, 2, 16'h0020, "R5 request write ignored");
    rd(0, 3, 16'h0000, "R7 sel3 zero");
    check("R2 group1 irq masked", {15'h0, irq_o[1]}, 16'h0);

    // clear armed bit 5
    wr(0, 0, 16'hFFDF);
    check("R11 irq still high", {15'h0, irq_o[0]}, 16'h1);
    @(negedge clk);
    check("R11 irq dropped", {15'h0, irq_o[0]}, 16'h0);
    rd(0, 0, 16'h0000, "R3 armed clear");

    // R9 collision: event and valid clear on bit 7 together
    pulse(src(7));
    rd(0, 0, 16'h0080, "R9 armed by read");
    evt_i = src(7);
    addr = 3'b000;
    wdata = 16'hFF7F;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    evt_i = '0;
    wr(0, 0, 16'hFF7F);
    rd(0, 0, 16'h0080, "R9 event wins, disarmed");
    wr(0, 0, 16'hFF7F);
    rd(0, 0, 16'h0000, "R9 clear after reread");

    // group 1 full mask
    wr(1, 1, 16'hFFFF);
    rd(1, 2, 16'h0002, "R5 group1 request");
    check("R11 group1 irq", {15'h0, irq_o[1]}, 16'h1);
    rd(1, 1, 16'hFFFF, "R6 group1 mask");

    repeat (3) @(negedge clk);
    check("R12 scoreboard drained", 16'(sbq.size()), 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule